// File: doc/BRIEF.md
# Adder Stress-Test Pattern Engine

This block is an on-chip test engine for a small 4-bit ripple-carry adder. After a start request it drives a stream of pseudo-random operand pairs onto the adder's two inputs and holds the adder's carry-in low. One pattern period after each pair is applied, it samples the adder's 4-bit sum and compares it against its own reference. Each run scores a fixed number of patterns, 1024, and reports how many matched as a count and as an integer percentage.

The pattern rate is set per run by a rate-select field. The field picks a clock-enable period of a power of two cycles, from every cycle down to one pattern per 2^20 cycles. Repeating the run at several rates shows the rate at which the adder stops settling in time. The operand and sum pins are plain levels with no handshake. The engine owns the pace, and the adder under test is combinational, so there is no back-pressure to manage. A run cannot be stalled or aborted except through reset.

Top module: `adder_bist_engine`

## Requirements
- R1: `carry_in_o` is 0 at all times, including during reset and between runs.
- R2: Operands come from a 16-bit shift register. Each step shifts it left by one and loads bit 0 with bit15 XOR bit14 XOR bit12 XOR bit3. `op_a_o` shows bits 3:0 and `op_b_o` shows bits 7:4. On an accepted start, the register is loaded with `seed_i`, or with 16'hACE1 when `seed_i` is 0. That loaded value is the first pattern, visible from the cycle after the start edge.
- R3: With an effective select `s`, the select clamped to at most 20, the operands advance exactly 2^s cycles after the start edge and then every 2^s cycles. A select above 20 behaves as 20.
- R4: A run scores exactly 1024 patterns. `done_o` is a single-cycle pulse raised on the edge of the last comparison, which comes 1024·2^s cycles after the start edge. `busy_o` falls on that same edge.
- R5: A pattern is a hit only when all four bits of `sum_i`, sampled at the tick after the pattern was applied, equal the low four bits of A+B+0 computed by a chain of full adders.
- R6: `hit_count_o` (11 bits, 0..1024) holds the run's hit total when `done_o` is high. It keeps that value until the next accepted start.
- R7: `hit_pct_o` equals floor(`hit_count_o`·100/1024), so a perfect run reads 100.
- R8: A start request while `busy_o` is high is ignored. It does not reload the seed, restart the count or change the result.
- R9: After reset, `busy_o`=0, `done_o`=0, `hit_count_o`=0, `hit_pct_o`=0, and the operands show the fallback seed (A=4'h1, B=4'hE).
- R10: Each accepted start clears the hit count and reseeds. A run repeated with the same seed and rate gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, accepted only while idle |
| rate_sel_i | input | 5 | Pattern period exponent, period = 2^min(sel,20) cycles |
| seed_i | input | 16 | Pattern register start value, 0 selects the fallback |
| op_a_o | output | 4 | Operand A to the adder under test |
| op_b_o | output | 4 | Operand B to the adder under test |
| carry_in_o | output | 1 | Carry-in to the adder under test, tied low |
| sum_i | input | 4 | Sum returned by the adder under test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| hit_count_o | output | 11 | Number of matching patterns |
| hit_pct_o | output | 7 | Integer hit percentage |

## Verification
The assertions watch, on every cycle, that the registered reference always equals the sum of the operands on the pins and that the pattern register never reaches zero. They also check that clock-enable ticks are spaced apart when the divide ratio exceeds one, that a start during a run leaves the operands untouched, that done is a lone pulse coinciding with busy falling, and that the count and percentage stay in range. Only the bench scenarios can show the full results. These are the exact hit totals against faulty adder models, the operand sequence and its timing at several rates, the zero-seed fallback, the clamp of large selects, and that identical runs repeat.

// File: rtl/adder_bist_pkg.sv
package adder_bist_pkg;
  localparam int unsigned OPND_W     = 4;
  localparam int unsigned PAT_REG_W  = 16;
  localparam int unsigned RUN_LEN    = 1024;
  localparam int unsigned RATE_SEL_W = 5;
  localparam int unsigned RATE_MAX   = 20;
  localparam logic [15:0] SEED_FALLBACK = 16'hACE1;
  localparam logic [15:0] TAP_MASK      = 16'hD008;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/bist_rate_div.sv
module bist_rate_div #(
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned SEL_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (SEL_MAX < 1) ? 1 : SEL_MAX;

  logic [SEL_W-1:0] sel_eff;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   limit;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    sel_eff = (sel_i > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel_i;
    span    = (CNT_W+1)'(1) << sel_eff;
    limit   = span - (CNT_W+1)'(1);
  end

  assign tick_o = run_i && (cnt_q == limit[CNT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || !run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_eff != '0) |=> (!tick_o || sel_eff == '0));
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned           W     = 16,
  parameter int unsigned           OUT_W = 8,
  parameter logic [W-1:0]          TAPS  = 16'hD008,
  parameter logic [W-1:0]          FALLBACK = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     seed_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] cur_o,
  output logic [OUT_W-1:0] nxt_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] stepped;
  logic [W-1:0] state_d;

  always_comb begin
    stepped = {state_q[W-2:0], ^(state_q & TAPS)};
    if (load_i) begin
      state_d = (seed_i == '0) ? FALLBACK : seed_i;
    end else if (step_i) begin
      state_d = stepped;
    end else begin
      state_d = state_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FALLBACK;
    end else begin
      state_q <= state_d;
    end
  end

  assign cur_o = state_q[OUT_W-1:0];
  assign nxt_o = state_d[OUT_W-1:0];

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/bist_ref_adder.sv
module bist_ref_adder #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p          = a_i[i] ^ b_i[i];
    assign sum_o[i]   = p ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & p);
  end

  // R5
  always_comb begin
    if (&a_i && &b_i) begin
      all_ones_carry_chk: assert (carry[W] == 1'b1);
    end
  end
endmodule

// File: rtl/bist_score.sv
module bist_score #(
  parameter int unsigned PATTERNS = 1024,
  parameter int unsigned PCT_W    = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           cmp_i,
  input  logic                           hit_i,
  output logic [$clog2(PATTERNS+1)-1:0]  hits_o,
  output logic [PCT_W-1:0]               pct_o
);
  localparam int unsigned HIT_W  = $clog2(PATTERNS+1);
  localparam int unsigned SHIFT  = $clog2(PATTERNS);
  localparam int unsigned PROD_W = SHIFT + PCT_W;

  logic [HIT_W-1:0]  hits_q;
  logic [PROD_W-1:0] hx;
  logic [PROD_W-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
    end else if (clear_i) begin
      hits_q <= '0;
    end else if (cmp_i && hit_i) begin
      hits_q <= hits_q + HIT_W'(1);
    end
  end

  always_comb begin
    hx   = PROD_W'(hits_q);
    prod = (hx << 6) + (hx << 5) + (hx << 2);
  end

  assign hits_o = hits_q;
  assign pct_o  = PCT_W'(prod >> SHIFT);

  // R6
  hits_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o <= HIT_W'(PATTERNS));

  // R7
  pct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pct_o <= PCT_W'(100));
endmodule

// File: rtl/adder_bist_engine.sv
module adder_bist_engine
  import adder_bist_pkg::*;
#(
  parameter int unsigned OP_W     = OPND_W,
  parameter int unsigned REG_W    = PAT_REG_W,
  parameter int unsigned PATTERNS = RUN_LEN,
  parameter int unsigned SEL_W    = RATE_SEL_W,
  parameter int unsigned SEL_MAX  = RATE_MAX
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [SEL_W-1:0]              rate_sel_i,
  input  logic [REG_W-1:0]              seed_i,
  output logic [OP_W-1:0]               op_a_o,
  output logic [OP_W-1:0]               op_b_o,
  output logic                          carry_in_o,
  input  logic [OP_W-1:0]               sum_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [$clog2(PATTERNS+1)-1:0] hit_count_o,
  output logic [6:0]                    hit_pct_o
);
  localparam int unsigned IDX_W  = $clog2(PATTERNS);
  localparam int unsigned PAIR_W = 2 * OP_W;

  run_state_e       state_q;
  logic             start_acc;
  logic             tick;
  logic             last_cmp;
  logic             hit;
  logic [IDX_W-1:0] idx_q;
  logic [OP_W-1:0]  ref_q;
  logic [OP_W-1:0]  ref_nxt;
  logic [PAIR_W-1:0] pair_cur;
  logic [PAIR_W-1:0] pair_nxt;
  logic             step;

  assign busy_o     = (state_q == ST_RUN);
  assign start_acc  = start_i && !busy_o;
  assign last_cmp   = tick && (idx_q == IDX_W'(PATTERNS - 1));
  assign step       = tick && !last_cmp;
  assign hit        = (sum_i == ref_q);
  assign carry_in_o = 1'b0;
  assign op_a_o     = pair_cur[OP_W-1:0];
  assign op_b_o     = pair_cur[PAIR_W-1:OP_W];

  bist_rate_div #(
    .SEL_W   (SEL_W),
    .SEL_MAX (SEL_MAX)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .run_i   (busy_o),
    .sel_i   (rate_sel_i),
    .tick_o  (tick)
  );

  bist_lfsr #(
    .W        (REG_W),
    .OUT_W    (PAIR_W),
    .TAPS     (REG_W'(TAP_MASK)),
    .FALLBACK (REG_W'(SEED_FALLBACK))
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_acc),
    .seed_i (seed_i),
    .step_i (step),
    .cur_o  (pair_cur),
    .nxt_o  (pair_nxt)
  );

  bist_ref_adder #(
    .W (OP_W)
  ) u_ref (
    .a_i   (pair_nxt[OP_W-1:0]),
    .b_i   (pair_nxt[PAIR_W-1:OP_W]),
    .sum_o (ref_nxt)
  );

  bist_score #(
    .PATTERNS (PATTERNS),
    .PCT_W    (7)
  ) u_score (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .cmp_i   (tick),
    .hit_i   (hit),
    .hits_o  (hit_count_o),
    .pct_o   (hit_pct_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ref_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_acc) begin
        state_q <= ST_RUN;
        idx_q   <= '0;
        ref_q   <= ref_nxt;
      end else if (last_cmp) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
      end else if (step) begin
        idx_q <= idx_q + IDX_W'(1);
        ref_q <= ref_nxt;
      end
    end
  end

  // R5
  ref_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (ref_q == OP_W'(op_a_o + op_b_o)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !tick) |=> ($stable(op_a_o) && $stable(op_b_o) && busy_o));
endmodule

// File: tb/adder_bist_engine_tb.sv
module adder_bist_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  rate_sel = '0;
  logic [15:0] seed = '0;
  logic [3:0]  op_a, op_b, dut_sum;
  logic        cin, busy, done;
  logic [10:0] hits;
  logic [6:0]  pct;
  logic [1:0]  fault = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  adder_bist_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rate_sel_i(rate_sel),
    .seed_i(seed), .op_a_o(op_a), .op_b_o(op_b), .carry_in_o(cin),
    .sum_i(dut_sum), .busy_o(busy), .done_o(done),
    .hit_count_o(hits), .hit_pct_o(pct)
  );

  function automatic logic [3:0] adder_model(input logic [3:0] a, input logic [3:0] b,
                                             input logic [1:0] f);
    logic [3:0] s;
    s = a + b;
    case (f)
      2'd1: s = s & 4'b1011;
      2'd2: if (a == b) s = s ^ 4'b0001;
      2'd3: if (a[3] & b[3]) s = s ^ 4'b1000;
      default: ;
    endcase
    return s;
  endfunction

  always_comb dut_sum = adder_model(op_a, op_b, fault);

  function automatic logic [15:0] fix_seed(input logic [15:0] s);
    return (s == 16'h0) ? 16'hACE1 : s;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic int expect_hits(input logic [15:0] s0, input logic [1:0] f);
    logic [15:0] s;
    int h;
    s = fix_seed(s0);
    h = 0;
    for (int i = 0; i < 1024; i++) begin
      if (adder_model(s[3:0], s[7:4], f) == 4'(s[3:0] + s[7:4])) h++;
      s = lfsr_next(s);
    end
    return h;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_vec(input logic [4:0] sel, input logic [1:0] f, input logic [15:0] sd,
                         input bit poke, output int got);
    logic [15:0] p0;
    int t0, exp_h, guard;
    fault = f; rate_sel = sel; seed = sd;
    p0 = fix_seed(sd);
    exp_h = expect_hits(sd, f);
    pulse_start();
    t0 = cyc;
    check("R2", "first pattern", int'({op_b, op_a}), int'(p0[7:0]));
    check("R10", "hits cleared at start", int'(hits), 0);
    check("R4", "busy after start", int'(busy), 1);
    if (sel != 0) begin
      repeat ((1 << sel) - 1) @(negedge clk);
      check("R3", "pattern held", int'({op_b, op_a}), int'(p0[7:0]));
    end
    @(negedge clk);
    check("R3", "second pattern", int'({op_b, op_a}), int'(lfsr_next(p0) & 16'h00FF));
    if (poke) begin
      seed = ~sd;
      pulse_start();   // R8: ignored while busy
    end
    guard = 0;
    while (!done && guard < (1024 << sel) + 64) begin
      @(negedge clk);
      guard++;
    end
    got = int'(hits);
    if (!done) begin
      check("R4", "run timeout", 0, 1);
    end else begin
      check(poke ? "R8" : "R5", "hit count", int'(hits), exp_h);
      check("R7", "percentage", int'(pct), (exp_h * 100) / 1024);
      check("R4", "busy at done", int'(busy), 0);
      check("R4", "run length", cyc - t0, 1024 << sel);
      @(negedge clk);
      check("R4", "done single cycle", int'(done), 0);
      check("R6", "count held", int'(hits), exp_h);
    end
  endtask

  localparam logic [22:0] VECS [0:4] = '{
    {5'd0, 2'd0, 16'h0001},
    {5'd1, 2'd1, 16'hBEEF},
    {5'd0, 2'd2, 16'h0000},
    {5'd2, 2'd3, 16'h5A5A},
    {5'd0, 2'd1, 16'hFFFF}
  };

  initial begin
    #2_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int first, again;
    first = 0;
    repeat (3) @(negedge clk);
    check("R9", "busy reset", int'(busy), 0);
    check("R9", "done reset", int'(done), 0);
    check("R9", "hits reset", int'(hits), 0);
    check("R9", "pct reset", int'(pct), 0);
    check("R1", "carry-in in reset", int'(cin), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R9", "operands after reset", int'({op_b, op_a}), 8'hE1);

    for (int i = 0; i < 5; i++) begin
      int got;
      run_vec(VECS[i][22:18], VECS[i][17:16], VECS[i][15:0], i == 1, got);
      if (i == 0) begin
        first = got;
        check("R7", "perfect score", int'(pct), 100);
      end
      check("R1", "carry-in idle", int'(cin), 0);
    end

    run_vec(5'd0, 2'd0, 16'h0001, 1'b0, again);
    check("R10", "repeat run", again, first);

    fault = 2'd0; rate_sel = 5'd21; seed = 16'h1234;
    pulse_start();
    repeat (2000) @(negedge clk);
    check("R3", "clamped select still busy", int'(busy), 1);
    check("R3", "clamped select holds pattern", int'({op_b, op_a}), 8'h34);
    check("R1", "carry-in running", int'(cin), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "reset aborts run", int'(busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule